// File: doc/BRIEF.md
# Fetch Stage Status Controller

This block decides, once per cycle, what the instruction fetch stage of an out-of-order pipeline does. It watches squash, mispredict and stall indications from the decode, rename, execute and commit stages, and the result of the fetch stage's own cache access: a miss flag, a fault flag and a later completion pulse. It holds the stage status as one of six values. From that status it produces a PC redirect, a fetch-enable strobe, a new-line request strobe, branch predictor squash and update commands, a cancel request for an outstanding instruction-cache miss, and three saturating cycle counters.

The inputs are weighed in a fixed order: first a commit squash, then commit's report that the reorder buffer is still squashing, then a decode squash, and then the stalls. All outputs except the status and the counters are combinational functions of the current status and this cycle's inputs. The status and the counters change on the next rising clock edge. Cache lookup, address translation, predictor internals and instruction extraction belong to other blocks.

Top module: `fetch_status_ctrl`

## Requirements
- R1: While `rst_n` is low, the next clock edge sets the status to Idle and clears all three counters. Status codes on `status_o`: Idle=0, Running=1, Squashing=2, Blocked=3, MissStall=4, MissComplete=5.
- R2: A commit squash takes priority over every other input. It drives a redirect to `cmt_next_pc`, gives no fetch that cycle, sets the status to Squashing and adds one to the squash counter.
- R3: A commit squash with `cmt_mispredict` set issues a predictor squash that carries the sequence number, `bp_sq_fix`=1, the corrected target and the taken bit. Without the flag it carries only the sequence number, with fix, target and taken all 0. When there is no commit squash and `cmt_seq` is nonzero, a predictor update for `cmt_seq` is issued.
- R4: While `cmt_rob_squashing` is set and there is no commit squash, the status becomes Squashing and the squash counter is incremented. There is no fetch and no redirect.
- R5: A decode squash that reaches its priority level always issues a predictor squash, formed as in R3 from the decode fields. It redirects to `dec_next_pc` and enters Squashing, counting a squash cycle, only when the status is not already Squashing.
- R6: If any of the four stall inputs is high and no higher-priority event applies, the status becomes Blocked and the blocked counter is incremented, whatever the current status.
- R7: From Blocked with all stalls low, the status moves to Running. No fetch occurs that cycle, and a blocked cycle is still counted.
- R8: From Squashing, with no squash, reorder-buffer squash or stall active, the stage fetches in that same cycle.
- R9: In MissStall there is no fetch. `icache_done` moves the status to MissComplete only when it arrives in MissStall; at any other time it is ignored. The fetch that follows from MissComplete raises no `line_req` and returns the status to Running.
- R10: `icache_cancel` is high exactly when a redirect is driven while the status is MissStall.
- R11: A fetch from Idle, Running or Squashing raises `line_req`. If that request faults, the status becomes Blocked. If it misses without a fault, the status becomes MissStall. Otherwise the status becomes Running.
- R12: Idle behaves like Running in the fetch decision.
- R13: Each fetch, squash or blocked cycle adds one to its own counter, and each counter stops at its all-ones value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmt_squash | input | 1 | Squash from commit |
| cmt_mispredict | input | 1 | Commit squash comes from a branch mispredict |
| cmt_taken | input | 1 | Resolved direction of the mispredicted branch (commit) |
| cmt_seq | input | SEQ_W | Sequence number reported by commit (0 = none) |
| cmt_next_pc | input | PC_W | Corrected PC from commit |
| cmt_rob_squashing | input | 1 | Reorder buffer is still squashing |
| cmt_stall | input | 1 | Stall from commit |
| dec_squash | input | 1 | Squash from decode |
| dec_mispredict | input | 1 | Decode squash comes from a mispredict |
| dec_taken | input | 1 | Resolved direction (decode) |
| dec_seq | input | SEQ_W | Sequence number from decode |
| dec_next_pc | input | PC_W | Corrected PC from decode |
| dec_stall | input | 1 | Stall from decode |
| ren_stall | input | 1 | Stall from rename |
| exe_stall | input | 1 | Stall from execute |
| icache_done | input | 1 | Outstanding cache miss has completed |
| fetch_fault | input | 1 | This cycle's line request faulted |
| line_miss | input | 1 | This cycle's line request missed in the cache |
| status_o | output | 3 | Current stage status code |
| fetch_en | output | 1 | Stage fetches this cycle |
| line_req | output | 1 | A new cache line request is issued this cycle |
| redirect_valid | output | 1 | PC redirect this cycle |
| redirect_pc | output | PC_W | Redirect target |
| icache_cancel | output | 1 | Cancel the outstanding cache miss |
| bp_sq_valid | output | 1 | Predictor squash command |
| bp_sq_seq | output | SEQ_W | Sequence number for the predictor squash |
| bp_sq_fix | output | 1 | Squash carries a corrected target |
| bp_sq_target | output | PC_W | Corrected target |
| bp_sq_taken | output | 1 | Corrected direction |
| bp_upd_valid | output | 1 | Predictor update command |
| bp_upd_seq | output | SEQ_W | Sequence number to update |
| fetch_cycles | output | CNT_W | Saturating count of fetch cycles |
| squash_cycles | output | CNT_W | Saturating count of squash cycles |
| blocked_cycles | output | CNT_W | Saturating count of blocked cycles |

## Verification
The status appears on `status_o` one edge after the cycle that decides it, so a wrong next-state choice shows up at the ports on the very next cycle. It also shows through `fetch_en`, `line_req` and the counters, since each of these depends on the current status. A MissStall or MissComplete that is lost or invented appears as a missing or extra `line_req` on the following cycles. A miscount shows directly in the counter that was stepped. The predictor commands and the redirect are combinational, so a priority error shows in the same cycle as the stimulus that triggered it.

// File: rtl/fetch_status_pkg.sv
// Shared types for the fetch stage status controller.
// Assumes a 3-bit status code that is visible on the top-level port.
package fetch_status_pkg;

    typedef enum logic [2:0] {
        FS_IDLE      = 3'd0,
        FS_RUN       = 3'd1,
        FS_SQUASH    = 3'd2,
        FS_BLOCK     = 3'd3,
        FS_MISS      = 3'd4,
        FS_MISS_DONE = 3'd5
    } fstat_e;

    localparam int unsigned NUM_CNT    = 3;
    localparam int unsigned CNT_FETCH  = 0;
    localparam int unsigned CNT_SQUASH = 1;
    localparam int unsigned CNT_BLOCK  = 2;

endpackage

// File: rtl/fetch_prio_decode.sv
// Priority decoder: from the current status and this cycle's control inputs,
// picks the next status, the fetch and line-request strobes, which redirect
// source wins, and which counters step.
// Assumes the line request result (fault/miss) is valid in the cycle of line_req.
module fetch_prio_decode
    import fetch_status_pkg::*;
(
    input  fstat_e             cur,
    input  logic               cmt_squash,
    input  logic               cmt_rob_squashing,
    input  logic               dec_squash,
    input  logic               stall_any,
    input  logic               icache_done,
    input  logic               fetch_fault,
    input  logic               line_miss,
    output fstat_e             nxt,
    output logic               take_cmt,
    output logic               take_dec,
    output logic               dec_bp_cmd,
    output logic               fetch_en,
    output logic               line_req,
    output logic [NUM_CNT-1:0] cnt_inc
);

    // Fixed priority chain: commit squash, ROB squashing, decode squash, stalls, fetch.
    always_comb begin
        nxt        = cur;
        take_cmt   = 1'b0;
        take_dec   = 1'b0;
        dec_bp_cmd = 1'b0;
        fetch_en   = 1'b0;
        line_req   = 1'b0;
        cnt_inc    = '0;
        if (cmt_squash) begin
            take_cmt            = 1'b1;
            nxt                 = FS_SQUASH;
            cnt_inc[CNT_SQUASH] = 1'b1;
        end else if (cmt_rob_squashing) begin
            nxt                 = FS_SQUASH;
            cnt_inc[CNT_SQUASH] = 1'b1;
        end else begin
            dec_bp_cmd = dec_squash;
            if (dec_squash && (cur != FS_SQUASH)) begin
                take_dec            = 1'b1;
                nxt                 = FS_SQUASH;
                cnt_inc[CNT_SQUASH] = 1'b1;
            end else if (stall_any) begin
                nxt                = FS_BLOCK;
                cnt_inc[CNT_BLOCK] = 1'b1;
            end else if (cur == FS_BLOCK) begin
                nxt                = FS_RUN;
                cnt_inc[CNT_BLOCK] = 1'b1;
            end else if (cur == FS_MISS) begin
                nxt = icache_done ? FS_MISS_DONE : FS_MISS;
            end else begin
                fetch_en           = 1'b1;
                cnt_inc[CNT_FETCH] = 1'b1;
                if (cur == FS_MISS_DONE) begin
                    nxt = FS_RUN;
                end else begin
                    line_req = 1'b1;
                    if (fetch_fault)    nxt = FS_BLOCK;
                    else if (line_miss) nxt = FS_MISS;
                    else                nxt = FS_RUN;
                end
            end
        end
    end

endmodule

// File: rtl/fetch_cmd_mux.sv
// Command mux: forms the PC redirect, the miss cancel and the predictor
// squash/update commands from whichever source the priority decoder picked.
// Assumes take_cmt and take_dec are never both high.
module fetch_cmd_mux
    import fetch_status_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned SEQ_W = 16
) (
    input  fstat_e             cur,
    input  logic               take_cmt,
    input  logic               take_dec,
    input  logic               dec_bp_cmd,
    input  logic               cmt_squash,
    input  logic               cmt_mispredict,
    input  logic               cmt_taken,
    input  logic [SEQ_W-1:0]   cmt_seq,
    input  logic [PC_W-1:0]    cmt_next_pc,
    input  logic               dec_mispredict,
    input  logic               dec_taken,
    input  logic [SEQ_W-1:0]   dec_seq,
    input  logic [PC_W-1:0]    dec_next_pc,
    output logic               redirect_valid,
    output logic [PC_W-1:0]    redirect_pc,
    output logic               icache_cancel,
    output logic               bp_sq_valid,
    output logic [SEQ_W-1:0]   bp_sq_seq,
    output logic               bp_sq_fix,
    output logic [PC_W-1:0]    bp_sq_target,
    output logic               bp_sq_taken,
    output logic               bp_upd_valid,
    output logic [SEQ_W-1:0]   bp_upd_seq
);

    // Redirect target and cancel of an outstanding miss.
    always_comb begin
        redirect_valid = take_cmt | take_dec;
        redirect_pc    = '0;
        if (take_cmt)      redirect_pc = cmt_next_pc;
        else if (take_dec) redirect_pc = dec_next_pc;
        icache_cancel  = redirect_valid && (cur == FS_MISS);
    end

    // Predictor squash from commit or decode, update from commit.
    always_comb begin
        bp_sq_valid  = 1'b0;
        bp_sq_seq    = '0;
        bp_sq_fix    = 1'b0;
        bp_sq_target = '0;
        bp_sq_taken  = 1'b0;
        if (cmt_squash) begin
            bp_sq_valid = 1'b1;
            bp_sq_seq   = cmt_seq;
            if (cmt_mispredict) begin
                bp_sq_fix    = 1'b1;
                bp_sq_target = cmt_next_pc;
                bp_sq_taken  = cmt_taken;
            end
        end else if (dec_bp_cmd) begin
            bp_sq_valid = 1'b1;
            bp_sq_seq   = dec_seq;
            if (dec_mispredict) begin
                bp_sq_fix    = 1'b1;
                bp_sq_target = dec_next_pc;
                bp_sq_taken  = dec_taken;
            end
        end
        bp_upd_valid = !cmt_squash && (cmt_seq != '0);
        bp_upd_seq   = bp_upd_valid ? cmt_seq : '0;
    end

endmodule

// File: rtl/fetch_sat_counter.sv
// Saturating event counter: adds one per cycle while inc is high, holds at all-ones.
// Assumes synchronous active-low reset.
module fetch_sat_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] MAXV = {W{1'b1}};

    // Count step with saturation.
    always_ff @(posedge clk) begin
        if (!rst_n)                    count <= '0;
        else if (inc && count != MAXV) count <= count + 1'b1;
    end

endmodule

// File: rtl/fetch_status_ctrl.sv
// Fetch stage status controller top: holds the stage status register, and
// instantiates the priority decoder, the command mux and one saturating
// counter per event class.
// Assumes all stage control inputs are valid for the whole cycle.
module fetch_status_ctrl
    import fetch_status_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned SEQ_W = 16,
    parameter int unsigned CNT_W = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmt_squash,
    input  logic               cmt_mispredict,
    input  logic               cmt_taken,
    input  logic [SEQ_W-1:0]   cmt_seq,
    input  logic [PC_W-1:0]    cmt_next_pc,
    input  logic               cmt_rob_squashing,
    input  logic               cmt_stall,
    input  logic               dec_squash,
    input  logic               dec_mispredict,
    input  logic               dec_taken,
    input  logic [SEQ_W-1:0]   dec_seq,
    input  logic [PC_W-1:0]    dec_next_pc,
    input  logic               dec_stall,
    input  logic               ren_stall,
    input  logic               exe_stall,
    input  logic               icache_done,
    input  logic               fetch_fault,
    input  logic               line_miss,
    output logic [2:0]         status_o,
    output logic               fetch_en,
    output logic               line_req,
    output logic               redirect_valid,
    output logic [PC_W-1:0]    redirect_pc,
    output logic               icache_cancel,
    output logic               bp_sq_valid,
    output logic [SEQ_W-1:0]   bp_sq_seq,
    output logic               bp_sq_fix,
    output logic [PC_W-1:0]    bp_sq_target,
    output logic               bp_sq_taken,
    output logic               bp_upd_valid,
    output logic [SEQ_W-1:0]   bp_upd_seq,
    output logic [CNT_W-1:0]   fetch_cycles,
    output logic [CNT_W-1:0]   squash_cycles,
    output logic [CNT_W-1:0]   blocked_cycles
);

    fstat_e             stat_q;
    fstat_e             stat_d;
    logic               take_cmt;
    logic               take_dec;
    logic               dec_bp_cmd;
    logic               stall_any;
    logic [NUM_CNT-1:0] cnt_inc;
    logic [CNT_W-1:0]   cnt_q [NUM_CNT];

    // Any downstream stage asking fetch to hold.
    always_comb stall_any = dec_stall | ren_stall | exe_stall | cmt_stall;

    fetch_prio_decode u_prio (
        .cur               (stat_q),
        .cmt_squash        (cmt_squash),
        .cmt_rob_squashing (cmt_rob_squashing),
        .dec_squash        (dec_squash),
        .stall_any         (stall_any),
        .icache_done       (icache_done),
        .fetch_fault       (fetch_fault),
        .line_miss         (line_miss),
        .nxt               (stat_d),
        .take_cmt          (take_cmt),
        .take_dec          (take_dec),
        .dec_bp_cmd        (dec_bp_cmd),
        .fetch_en          (fetch_en),
        .line_req          (line_req),
        .cnt_inc           (cnt_inc)
    );

    fetch_cmd_mux #(.PC_W(PC_W), .SEQ_W(SEQ_W)) u_cmd (
        .cur            (stat_q),
        .take_cmt       (take_cmt),
        .take_dec       (take_dec),
        .dec_bp_cmd     (dec_bp_cmd),
        .cmt_squash     (cmt_squash),
        .cmt_mispredict (cmt_mispredict),
        .cmt_taken      (cmt_taken),
        .cmt_seq        (cmt_seq),
        .cmt_next_pc    (cmt_next_pc),
        .dec_mispredict (dec_mispredict),
        .dec_taken      (dec_taken),
        .dec_seq        (dec_seq),
        .dec_next_pc    (dec_next_pc),
        .redirect_valid (redirect_valid),
        .redirect_pc    (redirect_pc),
        .icache_cancel  (icache_cancel),
        .bp_sq_valid    (bp_sq_valid),
        .bp_sq_seq      (bp_sq_seq),
        .bp_sq_fix      (bp_sq_fix),
        .bp_sq_target   (bp_sq_target),
        .bp_sq_taken    (bp_sq_taken),
        .bp_upd_valid   (bp_upd_valid),
        .bp_upd_seq     (bp_upd_seq)
    );

    // Stage status register.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= FS_IDLE;
        else        stat_q <= stat_d;
    end

    // One saturating counter per event class.
    for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
        fetch_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[g]),
            .count (cnt_q[g])
        );
    end

    // Port view of the state.
    always_comb begin
        status_o       = stat_q;
        fetch_cycles   = cnt_q[CNT_FETCH];
        squash_cycles  = cnt_q[CNT_SQUASH];
        blocked_cycles = cnt_q[CNT_BLOCK];
    end

endmodule

// File: rtl/fetch_status_chk.sv
// Checker for the fetch stage status controller; bound to the top below.
// Assumes it observes the top-level ports only.
module fetch_status_chk
    import fetch_status_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmt_squash,
    input logic             cmt_rob_squashing,
    input logic             cmt_stall,
    input logic             dec_stall,
    input logic             ren_stall,
    input logic             exe_stall,
    input logic [2:0]       status_o,
    input logic             fetch_en,
    input logic             line_req,
    input logic             redirect_valid,
    input logic             icache_cancel,
    input logic [CNT_W-1:0] fetch_cycles
);

    logic stall_seen;
    always_comb stall_seen = cmt_stall | dec_stall | ren_stall | exe_stall;

    // R2
    cmt_redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_squash |-> (redirect_valid && !fetch_en));
    // R2
    cmt_enter_sq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_squash |=> (status_o == FS_SQUASH));
    // R4
    rob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmt_rob_squashing && !cmt_squash) |-> (!fetch_en && !redirect_valid));
    // R6
    stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stall_seen && !cmt_squash && !cmt_rob_squashing && !redirect_valid)
            |=> (status_o == FS_BLOCK));
    // R7
    block_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == FS_BLOCK) |-> !fetch_en);
    // R9
    miss_nofetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == FS_MISS) |-> !fetch_en);
    // R9
    done_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == FS_MISS_DONE && fetch_en) |-> !line_req);
    // R10
    cancel_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        icache_cancel |-> (redirect_valid && status_o == FS_MISS));
    // R10
    cancel_need_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect_valid && status_o == FS_MISS) |-> icache_cancel);
    // R11
    req_in_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        line_req |-> fetch_en);
    // R13
    fetch_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |=> ((fetch_cycles == $past(fetch_cycles) + 1'b1) || (&fetch_cycles)));

endmodule

bind fetch_status_ctrl fetch_status_chk #(.CNT_W(CNT_W)) u_chk (
    .clk               (clk),
    .rst_n             (rst_n),
    .cmt_squash        (cmt_squash),
    .cmt_rob_squashing (cmt_rob_squashing),
    .cmt_stall         (cmt_stall),
    .dec_stall         (dec_stall),
    .ren_stall         (ren_stall),
    .exe_stall         (exe_stall),
    .status_o          (status_o),
    .fetch_en          (fetch_en),
    .line_req          (line_req),
    .redirect_valid    (redirect_valid),
    .icache_cancel     (icache_cancel),
    .fetch_cycles      (fetch_cycles)
);

// File: tb/sim_fetch_status_ctrl.sv
module sim_fetch_status_ctrl;
    import fetch_status_pkg::*;

    localparam int PC_W  = 16;
    localparam int SEQ_W = 8;
    localparam int CNT_W = 5;
    localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic cmt_squash = 0, cmt_mispredict = 0, cmt_taken = 0, cmt_rob_squashing = 0, cmt_stall = 0;
    logic [SEQ_W-1:0] cmt_seq = '0, dec_seq = '0;
    logic [PC_W-1:0]  cmt_next_pc = '0, dec_next_pc = '0;
    logic dec_squash = 0, dec_mispredict = 0, dec_taken = 0, dec_stall = 0;
    logic ren_stall = 0, exe_stall = 0, icache_done = 0, fetch_fault = 0, line_miss = 0;

    logic [2:0]       status_o;
    logic             fetch_en, line_req, redirect_valid, icache_cancel;
    logic [PC_W-1:0]  redirect_pc, bp_sq_target;
    logic             bp_sq_valid, bp_sq_fix, bp_sq_taken, bp_upd_valid;
    logic [SEQ_W-1:0] bp_sq_seq, bp_upd_seq;
    logic [CNT_W-1:0] fetch_cycles, squash_cycles, blocked_cycles;

    fetch_status_ctrl #(.PC_W(PC_W), .SEQ_W(SEQ_W), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst_n(rst_n),
        .cmt_squash(cmt_squash), .cmt_mispredict(cmt_mispredict), .cmt_taken(cmt_taken),
        .cmt_seq(cmt_seq), .cmt_next_pc(cmt_next_pc), .cmt_rob_squashing(cmt_rob_squashing),
        .cmt_stall(cmt_stall), .dec_squash(dec_squash), .dec_mispredict(dec_mispredict),
        .dec_taken(dec_taken), .dec_seq(dec_seq), .dec_next_pc(dec_next_pc),
        .dec_stall(dec_stall), .ren_stall(ren_stall), .exe_stall(exe_stall),
        .icache_done(icache_done), .fetch_fault(fetch_fault), .line_miss(line_miss),
        .status_o(status_o), .fetch_en(fetch_en), .line_req(line_req),
        .redirect_valid(redirect_valid), .redirect_pc(redirect_pc), .icache_cancel(icache_cancel),
        .bp_sq_valid(bp_sq_valid), .bp_sq_seq(bp_sq_seq), .bp_sq_fix(bp_sq_fix),
        .bp_sq_target(bp_sq_target), .bp_sq_taken(bp_sq_taken),
        .bp_upd_valid(bp_upd_valid), .bp_upd_seq(bp_upd_seq),
        .fetch_cycles(fetch_cycles), .squash_cycles(squash_cycles), .blocked_cycles(blocked_cycles)
    );

    int n_chk = 0;
    int n_fail = 0;

    // Reference state built from the requirements.
    fstat_e           m_st;
    logic [CNT_W-1:0] m_cnt [3];
    string            st_tag;

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic logic [CNT_W-1:0] sat_inc(logic [CNT_W-1:0] v, logic inc);
        return (inc && v != CMAX) ? v + 1'b1 : v;
    endfunction

    // Called after inputs are driven following a falling edge; checks outputs
    // and advances the reference state for the coming rising edge.
    task automatic step();
        logic e_fetch = 0, e_line = 0, e_redir = 0, e_cancel = 0;
        logic [PC_W-1:0] e_pc = '0, e_tgt = '0;
        logic e_sq = 0, e_fix = 0, e_tk = 0, e_upd = 0;
        logic [SEQ_W-1:0] e_sseq = '0, e_useq = '0;
        logic [2:0] inc = '0;
        fstat_e nx = m_st;
        string tag = "R12";
        logic stl = dec_stall | ren_stall | exe_stall | cmt_stall;
        #1;
        if (cmt_squash) begin
            e_redir = 1; e_pc = cmt_next_pc; e_cancel = (m_st == FS_MISS);
            nx = FS_SQUASH; inc[1] = 1; tag = "R2";
            e_sq = 1; e_sseq = cmt_seq; e_fix = cmt_mispredict;
            e_tgt = cmt_mispredict ? cmt_next_pc : '0; e_tk = cmt_mispredict & cmt_taken;
        end else begin
            e_upd = (cmt_seq != 0); e_useq = e_upd ? cmt_seq : '0;
            if (cmt_rob_squashing) begin
                nx = FS_SQUASH; inc[1] = 1; tag = "R4";
            end else begin
                if (dec_squash) begin
                    e_sq = 1; e_sseq = dec_seq; e_fix = dec_mispredict;
                    e_tgt = dec_mispredict ? dec_next_pc : '0; e_tk = dec_mispredict & dec_taken;
                end
                if (dec_squash && m_st != FS_SQUASH) begin
                    e_redir = 1; e_pc = dec_next_pc; e_cancel = (m_st == FS_MISS);
                    nx = FS_SQUASH; inc[1] = 1; tag = "R5";
                end else if (stl) begin
                    nx = FS_BLOCK; inc[2] = 1; tag = "R6";
                end else if (m_st == FS_BLOCK) begin
                    nx = FS_RUN; inc[2] = 1; tag = "R7";
                end else if (m_st == FS_MISS) begin
                    nx = icache_done ? FS_MISS_DONE : FS_MISS; tag = "R9";
                end else begin
                    e_fetch = 1; inc[0] = 1;
                    tag = (m_st == FS_SQUASH) ? "R8" : (m_st == FS_IDLE) ? "R12" : "R11";
                    if (m_st == FS_MISS_DONE) begin
                        nx = FS_RUN; tag = "R9";
                    end else begin
                        e_line = 1;
                        nx = fetch_fault ? FS_BLOCK : (line_miss ? FS_MISS : FS_RUN);
                    end
                end
            end
        end
        chk(st_tag, "status", status_o, m_st);
        chk(tag, "fetch_en/line_req", {fetch_en, line_req}, {e_fetch, e_line});
        chk(tag, "redirect", {redirect_valid, redirect_pc}, {e_redir, e_pc});
        chk("R10", "cancel", icache_cancel, e_cancel);
        chk((cmt_squash || !dec_squash) ? "R3" : "R5", "bp_squash",
            {bp_sq_valid, bp_sq_seq, bp_sq_fix, bp_sq_target, bp_sq_taken},
            {e_sq, e_sseq, e_fix, e_tgt, e_tk});
        chk("R3", "bp_update", {bp_upd_valid, bp_upd_seq}, {e_upd, e_useq});
        chk("R13", "counters", {fetch_cycles, squash_cycles, blocked_cycles},
            {m_cnt[0], m_cnt[1], m_cnt[2]});
        for (int i = 0; i < 3; i++) m_cnt[i] = sat_inc(m_cnt[i], inc[i]);
        m_st   = nx;
        st_tag = tag;
    endtask

    task automatic clear_inputs();
        cmt_squash = 0; cmt_mispredict = 0; cmt_taken = 0; cmt_seq = '0; cmt_next_pc = '0;
        cmt_rob_squashing = 0; cmt_stall = 0; dec_squash = 0; dec_mispredict = 0;
        dec_taken = 0; dec_seq = '0; dec_next_pc = '0; dec_stall = 0; ren_stall = 0;
        exe_stall = 0; icache_done = 0; fetch_fault = 0; line_miss = 0;
    endtask

    task automatic rand_inputs();
        cmt_squash        = ($urandom_range(11) == 0);
        cmt_mispredict    = $urandom_range(1);
        cmt_taken         = $urandom_range(1);
        cmt_seq           = ($urandom_range(2) == 0) ? '0 : SEQ_W'($urandom);
        cmt_next_pc       = PC_W'($urandom);
        cmt_rob_squashing = ($urandom_range(9) == 0);
        cmt_stall         = ($urandom_range(19) == 0);
        dec_squash        = ($urandom_range(7) == 0);
        dec_mispredict    = $urandom_range(1);
        dec_taken         = $urandom_range(1);
        dec_seq           = SEQ_W'($urandom);
        dec_next_pc       = PC_W'($urandom);
        dec_stall         = ($urandom_range(19) == 0);
        ren_stall         = ($urandom_range(19) == 0);
        exe_stall         = ($urandom_range(19) == 0);
        icache_done       = ($urandom_range(2) == 0);
        fetch_fault       = ($urandom_range(15) == 0);
        line_miss         = ($urandom_range(3) == 0);
    endtask

    initial begin
        #(5ns * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0f3c));
        clear_inputs();
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "status", status_o, FS_IDLE);
        chk("R1", "counters", {fetch_cycles, squash_cycles, blocked_cycles}, '0);
        m_st = FS_IDLE; st_tag = "R1";
        for (int i = 0; i < 3; i++) m_cnt[i] = '0;
        rst_n = 1'b1;

        // Directed: Idle fetch with miss (R12, R11), MissStall (R9)
        clear_inputs(); line_miss = 1; step();
        @(negedge clk); clear_inputs(); step();
        @(negedge clk); clear_inputs(); icache_done = 1; step();
        @(negedge clk); clear_inputs(); step();
        // New miss, then decode redirect during MissStall (R10)
        @(negedge clk); clear_inputs(); line_miss = 1; step();
        @(negedge clk); clear_inputs(); dec_squash = 1; dec_mispredict = 1; dec_taken = 1;
        dec_seq = 8'h21; dec_next_pc = 16'h4000; step();
        // Late completion ignored, fetch on squash exit (R8, R9)
        @(negedge clk); clear_inputs(); icache_done = 1; step();
        // Stall then unblock bubble (R6, R7)
        @(negedge clk); clear_inputs(); ren_stall = 1; step();
        @(negedge clk); clear_inputs(); step();
        @(negedge clk); clear_inputs(); step();
        // Fault on line request (R11)
        @(negedge clk); clear_inputs(); fetch_fault = 1; step();
        @(negedge clk); clear_inputs(); step();
        // Commit squash without mispredict, update with nonzero seq (R2, R3)
        @(negedge clk); clear_inputs(); cmt_squash = 1; cmt_seq = 8'h05; cmt_next_pc = 16'h0100; step();
        @(negedge clk); clear_inputs(); cmt_seq = 8'h07; step();
        // Decode squash while already Squashing (R5), ROB squashing (R4)
        @(negedge clk); clear_inputs(); cmt_rob_squashing = 1; step();
        @(negedge clk); clear_inputs(); dec_squash = 1; dec_seq = 8'h33; dec_next_pc = 16'h0200; step();

        for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            rand_inputs();
            step();
        end
        @(negedge clk); clear_inputs(); #1;
        chk(st_tag, "final status", status_o, m_st);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule